// File: doc/BRIEF.md
# Serial Port Interrupt Source Controller

This block gathers the three interrupt sources of a serial port: transmit done, receive done and receive error. Each source has a sticky pending bit and an enable bit. Software reaches both through a small register port with one select line. The pending bits are set by single-cycle strobes from the transmit and receive engines, which sit outside this block.

A single registered interrupt request goes to the CPU. It is raised when an enabled pending bit exists and the programmed 2-bit priority is strictly above the CPU's current 2-bit level.

The block also fixes the order in which a receive error and its receive-done indication reach software:
- On a parity or framing error, the error bit is set at once. The receive-done bit follows after a delay that depends on the bit-clock source.
- On an overrun, only the error bit is set.

Top module: `sio_irq_ctrl`

## Requirements
- R1: With `reg_sel`=0, a write loads the enable bits from `wr_data`. The bit positions are 0 for transmit done, 1 for receive done and 2 for receive error. The enable bits read back unchanged.
- R2: `rd_data` is registered. At each clock edge it captures the enable bits (`reg_sel`=0) or the pending bits (`reg_sel`=1), using the same bit positions as R1.
- R3: With `reg_sel`=1, writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R4: A source strobe sets its pending bit at the same clock edge, whatever the enable bits and the priority are.
- R5: When a set and a software clear of the same pending bit fall on the same edge, the bit ends up set.
- R6: A receive-done strobe with no error qualifier sets the receive-done pending bit at the same edge as the strobe.
- R7: A receive-done strobe with a parity or framing qualifier, in divider mode (`clk_src_tmr`=0), does two things. It sets the error pending bit at the strobe edge. It sets the receive-done pending bit exactly HALF_DLY edges later.
- R8: In timer mode (`clk_src_tmr`=1 at the strobe), the delayed receive-done set happens at the first edge after the strobe edge at which `tmr_uf` is high.
- R9: A receive-done strobe with the overrun qualifier sets the error pending bit and never sets the receive-done pending bit.
- R10: `irq_req` is high one edge after some bit is both pending and enabled while `irq_prio` > `cpu_lvl`. It is low one edge after that condition fails.
- R11: After reset, the enable bits, the pending bits, `rd_data` and `irq_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | 0 selects the enable register, 1 selects the pending register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 3 | Write data |
| rd_data | output | 3 | Registered read data |
| ev_tx_done | input | 1 | Transmit shift completed |
| ev_rx_done | input | 1 | Received byte moved to buffer |
| rx_par_err | input | 1 | Parity error qualifier for ev_rx_done |
| rx_frm_err | input | 1 | Framing error qualifier for ev_rx_done |
| rx_ovr_err | input | 1 | Overrun qualifier for ev_rx_done |
| clk_src_tmr | input | 1 | 1 when the bit clock comes from the timer |
| tmr_uf | input | 1 | Timer underflow strobe |
| irq_prio | input | 2 | Programmed priority of this port |
| cpu_lvl | input | 2 | Current CPU interrupt level |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
A hardware set and a software write-1 clear can target the same pending bit in the same cycle. The bench drives a transmit-done strobe and a pending-register write of 001 on one negative edge. After the next positive edge it reads the register back and expects bit 0 to be 1. The same collision is also applied to a delayed receive-done set, timed so that the clear lands on its firing edge.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int NSRC   = 3;
  localparam int LVL_W  = 2;
  localparam int SRC_TX = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_ER = 2;
  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/sio_rx_order.sv
module sio_rx_order #(
  parameter int HALF_DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_done,
  input  logic par_err,
  input  logic frm_err,
  input  logic ovr_err,
  input  logic clk_src_tmr,
  input  logic tmr_uf,
  output logic rx_set,
  output logic err_set
);
  localparam int CNT_W = (HALF_DLY > 1) ? $clog2(HALF_DLY) : 1;

  logic             pend_q, mode_q, fire;
  logic [CNT_W-1:0] cnt_q;
  logic             evt_clean, evt_pf, evt_ovr;

  assign evt_ovr   = rx_done & ovr_err;
  assign evt_pf    = rx_done & (par_err | frm_err) & ~ovr_err;
  assign evt_clean = rx_done & ~(par_err | frm_err | ovr_err);
  assign fire      = pend_q & (mode_q ? tmr_uf : (cnt_q == '0));
  assign err_set   = evt_pf | evt_ovr;
  assign rx_set    = evt_clean | fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else if (evt_pf) begin
      pend_q <= 1'b1;
      mode_q <= clk_src_tmr;
      cnt_q  <= CNT_W'(HALF_DLY - 1);
    end else if (fire) begin
      pend_q <= 1'b0;
    end else if (pend_q && !mode_q && cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R7: a parity/framing strobe never sets receive-done in its own cycle unless an older delay fires
  a_r7_err_first: assert property (@(posedge clk) disable iff (rst)
    (evt_pf && !pend_q) |-> !rx_set);
  // R8: in timer mode a delayed set needs the underflow strobe
  a_r8_tmr_gate: assert property (@(posedge clk) disable iff (rst)
    (pend_q && mode_q && !evt_clean && rx_set) |-> tmr_uf);
  // R9: overrun without an older pending delay gives no receive-done
  a_r9_ovr_quiet: assert property (@(posedge clk) disable iff (rst)
    (evt_ovr && !pend_q) |-> !rx_set);
endmodule

// File: rtl/sio_irq_regs.sv
module sio_irq_regs
  import sio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reg_sel,
  input  logic     wr_en,
  input  src_vec_t wr_data,
  input  src_vec_t hw_set,
  output src_vec_t en_q,
  output src_vec_t flag_q,
  output src_vec_t rd_data
);
  src_vec_t sw_clr;
  assign sw_clr = (wr_en && reg_sel) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst)                  en_q <= '0;
    else if (wr_en && !reg_sel) en_q <= wr_data;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flag_q[i] <= 1'b0;
      else if (hw_set[i]) flag_q[i] <= 1'b1;
      else if (sw_clr[i]) flag_q[i] <= 1'b0;
    end
    // R5 / R4: a set always lands
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
      hw_set[i] |=> flag_q[i]);
    // R3: a write-1 clear without a set empties the bit
    a_r3_clear: assert property (@(posedge clk) disable iff (rst)
      (sw_clr[i] && !hw_set[i]) |=> !flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= reg_sel ? flag_q : en_q;
  end

  // R1: enable write takes the bus value
  a_r1_en_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !reg_sel) |=> en_q == $past(wr_data));
endmodule

// File: rtl/sio_irq_arb.sv
module sio_irq_arb
  import sio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t en_q,
  input  src_vec_t flag_q,
  input  lvl_t     irq_prio,
  input  lvl_t     cpu_lvl,
  output logic     irq_req
);
  logic hit;
  assign hit = (|(en_q & flag_q)) && (irq_prio > cpu_lvl);

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= hit;
  end

  // R10: request only after an enabled pending bit under a higher priority
  a_r10_req_gate: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(irq_prio) > $past(cpu_lvl)) && $past(|(en_q & flag_q)));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int HALF_DLY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [NSRC-1:0]  wr_data,
  output logic [NSRC-1:0]  rd_data,
  input  logic             ev_tx_done,
  input  logic             ev_rx_done,
  input  logic             rx_par_err,
  input  logic             rx_frm_err,
  input  logic             rx_ovr_err,
  input  logic             clk_src_tmr,
  input  logic             tmr_uf,
  input  logic [LVL_W-1:0] irq_prio,
  input  logic [LVL_W-1:0] cpu_lvl,
  output logic             irq_req
);
  logic     rx_set, err_set;
  src_vec_t hw_set, en_q, flag_q;

  sio_rx_order #(.HALF_DLY(HALF_DLY)) u_order (
    .clk(clk), .rst(rst), .rx_done(ev_rx_done), .par_err(rx_par_err),
    .frm_err(rx_frm_err), .ovr_err(rx_ovr_err), .clk_src_tmr(clk_src_tmr),
    .tmr_uf(tmr_uf), .rx_set(rx_set), .err_set(err_set));

  always_comb begin
    hw_set         = '0;
    hw_set[SRC_TX] = ev_tx_done;
    hw_set[SRC_RX] = rx_set;
    hw_set[SRC_ER] = err_set;
  end

  sio_irq_regs u_regs (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .hw_set(hw_set), .en_q(en_q), .flag_q(flag_q),
    .rd_data(rd_data));

  sio_irq_arb u_arb (
    .clk(clk), .rst(rst), .en_q(en_q), .flag_q(flag_q),
    .irq_prio(irq_prio), .cpu_lvl(cpu_lvl), .irq_req(irq_req));

  // R11: the first edge after reset leaves the request low
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !irq_req);
endmodule

// File: tb/sim_sio_irq_ctrl.sv
module sim_sio_irq_ctrl;
  localparam int D = 4;
  logic clk = 0, rst = 1;
  logic reg_sel = 0, wr_en = 0;
  logic [2:0] wr_data = 0, rd_data;
  logic ev_tx_done = 0, ev_rx_done = 0, rx_par_err = 0, rx_frm_err = 0, rx_ovr_err = 0;
  logic clk_src_tmr = 0, tmr_uf = 0, irq_req;
  logic [1:0] irq_prio = 0, cpu_lvl = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sio_irq_ctrl #(.HALF_DLY(D)) u0 (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic sel, input logic [2:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(input logic sel, output logic [2:0] v);
    reg_sel = sel; tick(); v = rd_data;
  endtask

  task automatic clear_all(); wr(1, 3'b111); endtask

  task automatic t_reset();
    logic [2:0] v;
    chk("R11 req", {3'b0, irq_req}, 0);
    chk("R11 rd", {1'b0, rd_data}, 0);
    rd(0, v); chk("R11 enables", {1'b0, v}, 0);
    rd(1, v); chk("R11 flags", {1'b0, v}, 0);
  endtask

  task automatic t_enable();
    logic [2:0] v;
    wr(0, 3'b101); rd(0, v); chk("R1 en 101", {1'b0, v}, 4'h5);
    wr(0, 3'b010); rd(0, v); chk("R1 en 010", {1'b0, v}, 4'h2);
    wr(0, 3'b000);
  endtask

  task automatic t_flags();
    logic [2:0] v;
    irq_prio = 0; cpu_lvl = 3;
    ev_tx_done = 1; tick(); ev_tx_done = 0;
    rd(1, v); chk("R4 tx set while disabled", {1'b0, v}, 4'h1);
    chk("R2 rd shows flags", {1'b0, rd_data}, 4'h1);
    wr(1, 3'b000); rd(1, v); chk("R3 write 0 keeps", {1'b0, v}, 4'h1);
    wr(1, 3'b001); rd(1, v); chk("R3 write 1 clears", {1'b0, v}, 4'h0);
    ev_rx_done = 1; tick(); ev_rx_done = 0;
    rd(1, v); chk("R6 clean rx sets at once", {1'b0, v}, 4'h2);
    clear_all();
  endtask

  task automatic t_collide();
    logic [2:0] v;
    reg_sel = 1; wr_en = 1; wr_data = 3'b001; ev_tx_done = 1;
    tick();
    wr_en = 0; wr_data = 0; ev_tx_done = 0;
    rd(1, v); chk("R5 set beats clear", {1'b0, v}, 4'h1);
    clear_all();
    // delayed rx set fires at edge k+D; a clear lands on that edge
    ev_rx_done = 1; rx_frm_err = 1; tick(); ev_rx_done = 0; rx_frm_err = 0;
    for (int t = 1; t < D; t++) tick();
    wr(1, 3'b110);
    rd(1, v); chk("R5 delayed set beats clear", {1'b0, v}, 4'h2);
    clear_all();
  endtask

  task automatic t_pf_div();
    clk_src_tmr = 0; reg_sel = 1;
    ev_rx_done = 1; rx_par_err = 1; tick(); ev_rx_done = 0; rx_par_err = 0;
    for (int t = 1; t <= D + 1; t++) begin
      tick();
      if (t == 1) chk("R7 err first", {3'b0, rd_data[2]}, 1);
      chk("R7 rx delay", {3'b0, rd_data[1]}, (t >= D + 1) ? 4'h1 : 4'h0);
    end
    clear_all();
  endtask

  task automatic t_pf_tmr();
    clk_src_tmr = 1; reg_sel = 1;
    tmr_uf = 1;  // same-cycle strobe must not count
    ev_rx_done = 1; rx_frm_err = 1; tick(); ev_rx_done = 0; rx_frm_err = 0; tmr_uf = 0;
    clk_src_tmr = 0;  // mode latched at the strobe
    for (int t = 1; t <= D + 2; t++) tick();
    chk("R8 waits for underflow", {3'b0, rd_data[1]}, 0);
    chk("R8 err set", {3'b0, rd_data[2]}, 1);
    tmr_uf = 1; tick(); tmr_uf = 0;
    chk("R8 not before strobe edge", {3'b0, rd_data[1]}, 0);
    tick();
    chk("R8 set at underflow", {3'b0, rd_data[1]}, 1);
    clear_all();
  endtask

  task automatic t_ovr();
    logic [2:0] v;
    clk_src_tmr = 0; reg_sel = 1;
    ev_rx_done = 1; rx_ovr_err = 1; rx_par_err = 1; tick();
    ev_rx_done = 0; rx_ovr_err = 0; rx_par_err = 0;
    for (int t = 0; t < D + 3; t++) tick();
    rd(1, v); chk("R9 overrun only err", {1'b0, v}, 4'h4);
    clear_all();
  endtask

  task automatic t_irq();
    wr(0, 3'b001); irq_prio = 2; cpu_lvl = 1;
    ev_tx_done = 1; tick(); ev_tx_done = 0;
    chk("R10 not before register", {3'b0, irq_req}, 0);
    tick(); chk("R10 raised", {3'b0, irq_req}, 1);
    cpu_lvl = 2; tick(); tick(); chk("R10 equal level drops", {3'b0, irq_req}, 0);
    cpu_lvl = 0; tick(); tick(); chk("R10 lower level raises", {3'b0, irq_req}, 1);
    wr(0, 3'b110); tick(); chk("R10 disabled drops", {3'b0, irq_req}, 0);
    wr(0, 3'b001); tick(); chk("R10 reenabled", {3'b0, irq_req}, 1);
    clear_all(); tick(); chk("R10 cleared drops", {3'b0, irq_req}, 0);
    ev_rx_done = 1; tick(); ev_rx_done = 0; tick();
    chk("R10 other source not enabled", {3'b0, irq_req}, 0);
    clear_all(); wr(0, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    t_reset(); t_enable(); t_flags(); t_collide();
    t_pf_div(); t_pf_tmr(); t_ovr(); t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule